// File: doc/BRIEF.md
# Dual-Speed Cache Module Controller

This controller sits between two processor clusters and the two small first-level data cache modules beside them, one module per cluster. Each module runs in one of three operating points: a quick setting, a low-energy setting that takes twice as long, or powered down. At a context switch, system software writes a single mode word. The controller applies the new settings and holds back new accesses for a short settling window. It then returns every accepted access after the latency of the module that serves it.

A cluster whose own module is powered down is served by the other module, provided that module is active. When both modules are down, its accesses go to the second-level cache. Each response carries the request id and the cluster it came from. Responses from one module leave in the order their requests were accepted. When a module is switched from active to powered down, an invalidate pulse for that module is raised so that its lines are dropped.

Top module: `dual_speed_cache_ctrl`

## Requirements
- R1: Each module has a 2-bit mode field in `cfg_mode`: module 0 uses bits [1:0] and module 1 uses bits [3:2]. The codes are 00 = off, 01 = slow and 10 = fast. After reset both modules are fast and every output is low.
- R2: A field holding 11 is reserved. It leaves that module's mode unchanged, and the other field of the same write still takes effect.
- R3: An access accepted by a fast module shows `rsp_valid` two clock edges after the accepting edge. The accepting edge counts as the first of the two.
- R4: An access accepted by a slow module shows `rsp_valid` four clock edges after the accepting edge, counted the same way.
- R5: A write with `cfg_we` raises both `req_stall` bits for the RECONF_CYC (default 2) cycles that follow the write edge. An access accepted on the same edge as the write is served under the old modes.
- R6: An access from a cluster whose own module is off is served by the other module, if that module is active. It returns on the serving module's `rsp_valid`/`rsp_id`, and `rsp_src` gives the originating cluster (0 or 1).
- R7: When the owner of a module and a redirected cluster both request that module in the same cycle, the owner is accepted and the redirected cluster sees `req_stall`.
- R8: When both modules are off, an access is forwarded to L2. `l2_valid`/`l2_id` for that cluster appear one edge after acceptance.
- R9: A write that turns an active module off raises that module's `mod_inv` bit for exactly one cycle. A module that was already off gives no pulse.
- R10: The responses of one module leave in acceptance order, each carrying its own request id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode word write strobe (context switch) |
| cfg_mode | input | 4 | Mode fields, {module 1, module 0} |
| req_valid | input | 2 | Access request, one bit per cluster |
| req_id | input | 2*IDW | Request ids, cluster 1 in the upper half |
| req_stall | output | 2 | Request not accepted this cycle, per cluster |
| rsp_valid | output | 2 | Response valid, per module |
| rsp_id | output | 2*IDW | Response ids, module 1 in the upper half |
| rsp_src | output | 2 | Originating cluster of each module's response |
| l2_valid | output | 2 | Access forwarded to L2, per cluster |
| l2_id | output | 2*IDW | Ids of forwarded accesses |
| mod_inv | output | 2 | One-cycle invalidate pulse per module |

## Verification
The bench targets an access that arrives on the same edge as a mode write. A controller that applied the new modes one cycle early would serve that access at the new latency or on the wrong path, instead of under the old mode. A reserved code in one field is paired with a valid code in the other, which exposes a decoder that clears or corrupts the neighbouring module. Two clusters then compete for one surviving module, and both requests land in its slow pipeline. A wrong priority would stall the owner, and a pipeline that mishandled back-to-back entries would swap or drop ids. The invalidate pulse is checked on an active-to-off write and also on an off-to-off write, so a pulse that fires on every write of 00 is caught.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_SLOW = 2'b01,
    MODE_FAST = 2'b10
  } mode_e;

  localparam logic [1:0] MODE_RSVD = 2'b11;
  localparam int         NUM_MOD   = 2;
endpackage

// File: rtl/dsc_mode_ctrl.sv
module dsc_mode_ctrl
  import dsc_pkg::*;
#(
  parameter int RECONF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_mode,
  output mode_e      mode_q [NUM_MOD],
  output logic       busy,
  output logic [1:0] inv_q
);
  localparam int CW = $clog2(RECONF_CYC + 1);

  mode_e         mode_d [NUM_MOD];
  logic [1:0]    mode_en;
  logic [1:0]    inv_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    for (int m = 0; m < NUM_MOD; m++) begin
      mode_en[m] = cfg_we && (cfg_mode[2*m +: 2] != MODE_RSVD);
      mode_d[m]  = mode_en[m] ? mode_e'(cfg_mode[2*m +: 2]) : mode_q[m];
      inv_d[m]   = mode_en[m] && (cfg_mode[2*m +: 2] == MODE_OFF) &&
                   (mode_q[m] != MODE_OFF);
    end
    if (cfg_we)           cnt_d = CW'(RECONF_CYC);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  assign busy = (cnt_q != '0);

  generate
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mode_q[m] <= MODE_FAST;
        else if (mode_en[m]) mode_q[m] <= mode_d[m];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      inv_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      inv_q <= inv_d;
    end
  end
endmodule

// File: rtl/dsc_route.sv
module dsc_route
  import dsc_pkg::*;
#(
  parameter int IDW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode_q [NUM_MOD],
  input  logic             busy,
  input  logic [1:0]       req_valid,
  input  logic [2*IDW-1:0] req_id,
  output logic [1:0]       req_stall,
  output logic [1:0]       ins_valid,
  output logic [1:0]       ins_fast,
  output logic [2*IDW-1:0] ins_id,
  output logic [1:0]       ins_src,
  output logic [1:0]       l2_valid,
  output logic [2*IDW-1:0] l2_id
);
  logic [1:0]       l2_vd;
  logic [2*IDW-1:0] l2_idd;

  always_comb begin
    req_stall = {busy, busy};
    ins_valid = '0;
    ins_id    = '0;
    ins_src   = '0;
    l2_vd     = '0;
    l2_idd    = l2_id;
    for (int c = 0; c < NUM_MOD; c++) begin
      if (!busy && req_valid[c]) begin
        if (mode_q[c] != MODE_OFF) begin
          ins_valid[c]          = 1'b1;
          ins_id[c*IDW +: IDW]  = req_id[c*IDW +: IDW];
          ins_src[c]            = c[0];
        end else if (mode_q[1-c] != MODE_OFF) begin
          if (req_valid[1-c]) begin
            req_stall[c] = 1'b1;
          end else begin
            ins_valid[1-c]           = 1'b1;
            ins_id[(1-c)*IDW +: IDW] = req_id[c*IDW +: IDW];
            ins_src[1-c]             = c[0];
          end
        end else begin
          l2_vd[c]              = 1'b1;
          l2_idd[c*IDW +: IDW]  = req_id[c*IDW +: IDW];
        end
      end
    end
    for (int m = 0; m < NUM_MOD; m++) begin
      ins_fast[m] = (mode_q[m] == MODE_FAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l2_valid <= '0;
      l2_id    <= '0;
    end else begin
      l2_valid <= l2_vd;
      if (|l2_vd) l2_id <= l2_idd;
    end
  end
endmodule

// File: rtl/dsc_lat_pipe.sv
module dsc_lat_pipe #(
  parameter int IDW      = 4,
  parameter int FAST_LAT = 2,
  parameter int SLOW_LAT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ins_valid,
  input  logic           ins_fast,
  input  logic [IDW-1:0] ins_id,
  input  logic           ins_src,
  output logic           out_valid,
  output logic [IDW-1:0] out_id,
  output logic           out_src
);
  localparam int DEPTH    = SLOW_LAT;
  localparam int FAST_POS = DEPTH - FAST_LAT;
  localparam int SLOW_POS = DEPTH - SLOW_LAT;

  logic           v_q   [DEPTH];
  logic           v_d   [DEPTH];
  logic [IDW-1:0] id_q  [DEPTH];
  logic [IDW-1:0] id_d  [DEPTH];
  logic           src_q [DEPTH];
  logic           src_d [DEPTH];
  logic [DEPTH-1:0] ld_en;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 0) begin
        v_d[i]   = 1'b0;
        id_d[i]  = id_q[i];
        src_d[i] = src_q[i];
      end else begin
        v_d[i]   = v_q[i-1];
        id_d[i]  = id_q[i-1];
        src_d[i] = src_q[i-1];
      end
      if (ins_valid && (i == (ins_fast ? FAST_POS : SLOW_POS))) begin
        v_d[i]   = 1'b1;
        id_d[i]  = ins_id;
        src_d[i] = ins_src;
      end
      ld_en[i] = v_d[i];
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q[i] <= 1'b0;
        else        v_q[i] <= v_d[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          id_q[i]  <= '0;
          src_q[i] <= 1'b0;
        end else if (ld_en[i]) begin
          id_q[i]  <= id_d[i];
          src_q[i] <= src_d[i];
        end
      end
    end
  endgenerate

  assign out_valid = v_q[DEPTH-1];
  assign out_id    = id_q[DEPTH-1];
  assign out_src   = src_q[DEPTH-1];
endmodule

// File: rtl/dual_speed_cache_ctrl.sv
module dual_speed_cache_ctrl
  import dsc_pkg::*;
#(
  parameter int IDW        = 4,
  parameter int FAST_LAT   = 2,
  parameter int SLOW_LAT   = 4,
  parameter int RECONF_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_mode,
  input  logic [1:0]       req_valid,
  input  logic [2*IDW-1:0] req_id,
  output logic [1:0]       req_stall,
  output logic [1:0]       rsp_valid,
  output logic [2*IDW-1:0] rsp_id,
  output logic [1:0]       rsp_src,
  output logic [1:0]       l2_valid,
  output logic [2*IDW-1:0] l2_id,
  output logic [1:0]       mod_inv
);
  mode_e            mode_q [NUM_MOD];
  logic [3:0]       mode_flat;
  logic             busy;
  logic [1:0]       ins_valid;
  logic [1:0]       ins_fast;
  logic [2*IDW-1:0] ins_id;
  logic [1:0]       ins_src;

  assign mode_flat = {mode_q[1], mode_q[0]};

  dsc_mode_ctrl #(.RECONF_CYC(RECONF_CYC)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .mode_q   (mode_q),
    .busy     (busy),
    .inv_q    (mod_inv)
  );

  dsc_route #(.IDW(IDW)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .busy      (busy),
    .req_valid (req_valid),
    .req_id    (req_id),
    .req_stall (req_stall),
    .ins_valid (ins_valid),
    .ins_fast  (ins_fast),
    .ins_id    (ins_id),
    .ins_src   (ins_src),
    .l2_valid  (l2_valid),
    .l2_id     (l2_id)
  );

  generate
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_pipe
      dsc_lat_pipe #(
        .IDW      (IDW),
        .FAST_LAT (FAST_LAT),
        .SLOW_LAT (SLOW_LAT)
      ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid[m]),
        .ins_fast  (ins_fast[m]),
        .ins_id    (ins_id[m*IDW +: IDW]),
        .ins_src   (ins_src[m]),
        .out_valid (rsp_valid[m]),
        .out_id    (rsp_id[m*IDW +: IDW]),
        .out_src   (rsp_src[m])
      );
    end
  endgenerate
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int IDW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [3:0]       cfg_mode,
  input logic [1:0]       req_valid,
  input logic [2*IDW-1:0] req_id,
  input logic [1:0]       req_stall,
  input logic [1:0]       rsp_valid,
  input logic [2*IDW-1:0] rsp_id,
  input logic [1:0]       rsp_src,
  input logic [1:0]       l2_valid,
  input logic [1:0]       mod_inv,
  input logic [3:0]       mode_flat
);
  // R5: both clusters held off during the settling window
  a_r5_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (req_stall == 2'b11));
  a_r5_stall_second: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> ##2 (req_stall == 2'b11));

  generate
    for (genvar m = 0; m < 2; m++) begin : g_mod
      // R3: own-module fast access returns two edges later with its id
      a_r3_fast_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[m] && !req_stall[m] && mode_flat[2*m +: 2] == 2'b10)
        |-> ##2 (rsp_valid[m] && rsp_src[m] == m[0] &&
                 rsp_id[m*IDW +: IDW] == $past(req_id[m*IDW +: IDW], 2)));
      // R4: own-module slow access returns four edges later
      a_r4_slow_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[m] && !req_stall[m] && mode_flat[2*m +: 2] == 2'b01)
        |-> ##4 (rsp_valid[m] && rsp_src[m] == m[0]));
      // R8: L2 forward only follows a request from that cluster
      a_r8_l2_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        l2_valid[m] |-> $past(req_valid[m]));
      // R9: invalidate pulse only for a module now off
      a_r9_inv_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        mod_inv[m] |-> (mode_flat[2*m +: 2] == 2'b00));
      // R2: reserved code keeps the mode
      a_r2_reserved_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_mode[2*m +: 2] == 2'b11)
        |=> (mode_flat[2*m +: 2] == $past(mode_flat[2*m +: 2])));
      // R7: owner wins over redirected cluster
      a_r7_owner_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == 2'b11 && mode_flat[2*m +: 2] == 2'b00 &&
         mode_flat[2*(1-m) +: 2] != 2'b00 && !req_stall[1-m])
        |-> req_stall[m]);
    end
  endgenerate
endmodule

bind dual_speed_cache_ctrl dsc_checker #(.IDW(IDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_mode  (cfg_mode),
  .req_valid (req_valid),
  .req_id    (req_id),
  .req_stall (req_stall),
  .rsp_valid (rsp_valid),
  .rsp_id    (rsp_id),
  .rsp_src   (rsp_src),
  .l2_valid  (l2_valid),
  .mod_inv   (mod_inv),
  .mode_flat (mode_flat)
);

// File: tb/dual_speed_cache_ctrl_bench.sv
module dual_speed_cache_ctrl_bench;
  localparam int IDW = 4;
  localparam int NV  = 11;
  // {cfg{m1,m0}, cluster, id, path(0/1 module, 2 L2), latency}
  localparam logic [13:0] VEC [NV] = '{
    {4'b1010, 1'b0, 4'd1,  2'd0, 3'd2},
    {4'b1010, 1'b1, 4'd2,  2'd1, 3'd2},
    {4'b0110, 1'b1, 4'd3,  2'd1, 3'd4},
    {4'b0110, 1'b0, 4'd4,  2'd0, 3'd2},
    {4'b0101, 1'b0, 4'd5,  2'd0, 3'd4},
    {4'b0010, 1'b1, 4'd6,  2'd0, 3'd2},
    {4'b0001, 1'b1, 4'd7,  2'd0, 3'd4},
    {4'b1000, 1'b0, 4'd8,  2'd1, 3'd2},
    {4'b0100, 1'b0, 4'd9,  2'd1, 3'd4},
    {4'b0000, 1'b0, 4'd10, 2'd2, 3'd1},
    {4'b0000, 1'b1, 4'd11, 2'd2, 3'd1}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we = 1'b0;
  logic [3:0]       cfg_mode = '0;
  logic [1:0]       req_valid = '0;
  logic [2*IDW-1:0] req_id = '0;
  logic [1:0]       req_stall, rsp_valid, rsp_src, l2_valid, mod_inv;
  logic [2*IDW-1:0] rsp_id, l2_id;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;
  logic [3:0] cur_cfg;

  always #5 clk = ~clk;

  dual_speed_cache_ctrl u_dual_speed_cache_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .req_valid(req_valid), .req_id(req_id), .req_stall(req_stall),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_src(rsp_src),
    .l2_valid(l2_valid), .l2_id(l2_id), .mod_inv(mod_inv)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [3:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = v;
    @(negedge clk); cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(input logic [3:0] cfg, input int cl, input logic [IDW-1:0] id,
                         input int path, input int lat, input string tag);
    int got_k, got_p;
    logic [IDW-1:0] got_id;
    logic got_src;
    if (cfg != cur_cfg) begin
      write_cfg(cfg);
      cur_cfg = cfg;
    end
    @(negedge clk);
    req_valid[cl] = 1'b1;
    req_id[cl*IDW +: IDW] = id;
    #1 chk(req_stall[cl] == 1'b0, {tag, " not stalled"}, int'(req_stall[cl]), 0);
    got_k = 0; got_p = 3; got_id = '0; got_src = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = '0;
      if (got_k == 0) begin
        if (rsp_valid[0]) begin
          got_k = k; got_p = 0; got_id = rsp_id[IDW-1:0]; got_src = rsp_src[0];
        end else if (rsp_valid[1]) begin
          got_k = k; got_p = 1; got_id = rsp_id[2*IDW-1:IDW]; got_src = rsp_src[1];
        end else if (l2_valid[cl]) begin
          got_k = k; got_p = 2; got_id = l2_id[cl*IDW +: IDW]; got_src = cl[0];
        end
      end
    end
    chk(got_p == path, {tag, " path"}, got_p, path);
    chk(got_k == lat, {tag, " latency"}, got_k, lat);
    chk(got_id == id, {tag, " id"}, int'(got_id), int'(id));
    chk(got_src == cl[0], {tag, " src"}, int'(got_src), cl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cur_cfg = 4'b1010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_stall == 2'b00, "R1 reset stall", int'(req_stall), 0);
    chk(rsp_valid == 2'b00, "R1 reset rsp_valid", int'(rsp_valid), 0);
    chk(l2_valid == 2'b00, "R1 reset l2_valid", int'(l2_valid), 0);
    chk(mod_inv == 2'b00, "R1 reset mod_inv", int'(mod_inv), 0);

    // table walk (first entries use the reset modes: R1)
    for (int v = 0; v < NV; v++) begin
      logic [13:0] e;
      string tag;
      int cl, path, lat;
      e = VEC[v];
      cl = int'(e[9]); path = int'(e[4:3]); lat = int'(e[2:0]);
      if (v < 2)              tag = "R1";
      else if (path == 2)     tag = "R8";
      else if (path != cl)    tag = "R6";
      else if (lat == 2)      tag = "R3";
      else                    tag = "R4";
      run_vec(e[13:10], cl, e[8:5], path, lat, tag);
    end

    // R5: write with a same-edge access, old modes (both off) apply
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 4'b1010;
    req_valid = 2'b01; req_id = 8'h0C;
    #1 chk(req_stall == 2'b00, "R5 same-edge stall", int'(req_stall), 0);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = '0;
    chk(l2_valid[0] == 1'b1 && l2_id[3:0] == 4'hC, "R5 old mode L2", int'(l2_valid), 1);
    chk(req_stall == 2'b11, "R5 window cycle 1", int'(req_stall), 3);
    chk(mod_inv == 2'b00, "R9 no pulse off->on", int'(mod_inv), 0);
    @(negedge clk);
    chk(req_stall == 2'b11, "R5 window cycle 2", int'(req_stall), 3);
    @(negedge clk);
    chk(req_stall == 2'b00, "R5 window over", int'(req_stall), 0);

    // R5: in-flight fast access keeps its latency across a switch to slow
    cfg_we = 1'b1; cfg_mode = 4'b0101; req_valid = 2'b01; req_id = 8'h0D;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = '0;
    chk(rsp_valid[0] == 1'b0, "R5 in-flight early", int'(rsp_valid[0]), 0);
    @(negedge clk);
    chk(rsp_valid[0] && rsp_id[3:0] == 4'hD, "R5 in-flight old latency",
        int'(rsp_id[3:0]), 13);
    @(negedge clk);
    cur_cfg = 4'b0101;

    // R2: reserved field for module 1, module 0 goes fast
    write_cfg(4'b1110);
    cur_cfg = 4'b0110;
    run_vec(4'b0110, 1, 4'd12, 1, 4, "R2");
    run_vec(4'b0110, 0, 4'd13, 0, 2, "R2");

    // R9: module 0 active -> off gives one pulse
    @(negedge clk); cfg_we = 1'b1; cfg_mode = 4'b0100;
    @(negedge clk); cfg_we = 1'b0;
    chk(mod_inv == 2'b01, "R9 pulse", int'(mod_inv), 1);
    @(negedge clk);
    chk(mod_inv == 2'b00, "R9 one cycle", int'(mod_inv), 0);
    @(negedge clk);
    cur_cfg = 4'b0100;

    // R7 conflict, then R10 ordering in module 1 (slow)
    @(negedge clk);
    req_valid = 2'b11; req_id = {4'hE, 4'hF};
    #1 chk(req_stall == 2'b01, "R7 owner wins", int'(req_stall), 1);
    @(negedge clk);
    req_valid = 2'b01;
    #1 chk(req_stall == 2'b00, "R7 redirected next", int'(req_stall), 0);
    @(negedge clk);
    req_valid = '0;
    @(negedge clk);
    @(negedge clk);
    chk(rsp_valid[1] && rsp_id[7:4] == 4'hE && rsp_src[1] == 1'b1,
        "R10 first response", int'(rsp_id[7:4]), 14);
    @(negedge clk);
    chk(rsp_valid[1] && rsp_id[7:4] == 4'hF && rsp_src[1] == 1'b0,
        "R10 second response", int'(rsp_id[7:4]), 15);

    // R9: module 1 off gives a pulse, module 0 already off gives none
    @(negedge clk); cfg_we = 1'b1; cfg_mode = 4'b0000;
    @(negedge clk); cfg_we = 1'b0;
    chk(mod_inv == 2'b10, "R9 module 1 pulse only", int'(mod_inv), 2);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule